// File: doc/BRIEF.md
# Pipelined Single-Precision Multiply-Add Unit

This unit computes D = A*B + C on three single-precision floating-point operands. The result leaves on its own output and never overwrites any of the three sources. The product and the sum are rounded once, at the end, to nearest-even. A caller can issue one operation on every clock. Each operation carries a small destination tag, which comes back with the result, so the consumer knows where to write D.

The work is split over four register stages. The first unpacks the operands and forms the exact 48-bit significand product. The second lines the addend up against the product. The third adds, or subtracts, and normalises. The fourth rounds and packs the result. Up to four operations are in flight at once, and every result appears exactly four clocks after its operands were accepted.

The number handling is simplified. Inputs with a zero exponent field count as zero, whatever their fraction. Results too small for a normal number become a zero of the correct sign. Any invalid case gives one canonical quiet NaN. The unit raises no exception flags.

Top module: `fmaUnit`

## Requirements
- R1: For normal operands whose exact result has a normal exponent, outResult equals A*B+C computed exactly and then rounded once to a 24-bit significand.
- R2: outValid is 0 during and after reset until operations arrive, and outValid equals the inValid that was sampled exactly four rising edges earlier.
- R3: With every valid result, outTag returns the inTag that was sampled together with that operation's operands.
- R4: Operations presented on consecutive clocks, with no gaps, each produce a correct result on consecutive clocks.
- R5: Rounding is to nearest. When the discarded part is exactly half an ulp, the result with an even last significand bit is chosen.
- R6: An operand with exponent field 0 is treated as a zero of its sign bit, for any fraction value.
- R7: If the rounded biased exponent is below 1, the result is a signed zero (sign bit 31 = sign of the exact result, remaining bits 0). If it is 255 or more, the result is an infinity of that sign (exponent field 0xFF, fraction 0).
- R8: If any operand is a NaN (exponent field 0xFF, fraction nonzero), the result is 0x7FC00000. No other NaN encoding ever appears on outResult.
- R9: An infinity multiplied by a zero gives 0x7FC00000. So does an infinite product added to an infinite C of the opposite sign.
- R10: Any other case with an infinite product or an infinite C gives an infinity carrying the sign of whichever of the two is infinite.
- R11: An exact zero sum of nonzero terms gives +0 (0x00000000). A zero product plus a zero C gives a zero whose sign is the AND of the two signs.
- R12: A clock with inValid low produces no result four clocks later, whatever the operand inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and tag are presented this cycle |
| inTag | input | TAG_W (4) | Destination tag of the operation |
| opA | input | 32 | Multiplicand, single precision |
| opB | input | 32 | Multiplier, single precision |
| opC | input | 32 | Addend, single precision |
| outValid | output | 1 | outResult and outTag hold a finished operation |
| outTag | output | TAG_W (4) | Tag returned with the result |
| outResult | output | 32 | D = A*B + C, single precision |

## Verification
Every stage register feeds the next, so a wrong value held in any stage shows on outResult on the one cycle, four clocks after issue, that its operation leaves the pipe. It is then compared with a model that works from exact real arithmetic. A valid bit or tag that falls out of step shows at once as a result arriving on the wrong cycle, or carrying another operation's tag. Long runs of random back-to-back operations make sure that state left behind by one operation would corrupt a neighbour within four cycles. Directed cases cover half-ulp ties, cancellation to zero, flushing, overflow and every NaN and infinity rule.

// File: rtl/fmaPkg.sv
package fmaPkg;
  // binary32 field layout
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int EXT_W   = 3;                 // extra low bits kept during alignment
  localparam int ALIGN_W = PROD_W + EXT_W;
  localparam int SUM_W   = ALIGN_W + 1;       // one carry bit on top
  localparam int LZ_W    = $clog2(SUM_W + 1);
  localparam int EXPI_W  = EXP_W + 3;         // signed internal exponent
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int LATENCY = 4;
  localparam int GUARD_POS = SUM_W - 1 - SIG_W;

  localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef logic signed [EXPI_W-1:0] sexp_t;

  // exponent given to a zero operand so the other term always dominates
  localparam sexp_t EXP_FLOOR = sexp_t'(-(1 << (EXPI_W - 2)));

  typedef struct packed {
    logic nan;
    logic inf;
    logic infSign;
    logic bothZero;
    logic zeroSign;
  } special_t;

  typedef struct packed {
    special_t            sp;
    logic                pSign;
    logic                cSign;
    sexp_t               pExp;
    sexp_t               cExp;
    logic [PROD_W-1:0]   prod;
    logic [SIG_W-1:0]    cSig;
  } stage1_t;

  typedef struct packed {
    special_t            sp;
    logic                bigSign;
    logic                effSub;
    sexp_t               bigExp;
    logic [ALIGN_W-1:0]  bigSig;
    logic [ALIGN_W-1:0]  smallSig;
  } stage2_t;

  typedef struct packed {
    special_t            sp;
    logic                sign;
    sexp_t               exp;
    logic [SUM_W-1:0]    norm;
  } stage3_t;

  // stage load strobes from control to datapath
  typedef struct packed {
    logic [LATENCY-1:0] load;
  } strobe_t;

  function automatic logic [LZ_W-1:0] leadZeros(input logic [SUM_W-1:0] v);
    logic [LZ_W-1:0] n;
    n = LZ_W'(SUM_W);
    for (int i = 0; i < SUM_W; i++) begin
      if (v[i]) n = LZ_W'(SUM_W - 1 - i);
    end
    return n;
  endfunction
endpackage

// File: rtl/fmaCtrl.sv
module fmaCtrl
  import fmaPkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [TAG_W-1:0] inTag,
  output strobe_t          strobes,
  output logic             outValid,
  output logic [TAG_W-1:0] outTag
);
  logic [LATENCY-1:0] validQ;
  logic [TAG_W-1:0]   tagQ [LATENCY];

  for (genvar i = 0; i < LATENCY; i++) begin : gStage
    logic             validIn;
    logic [TAG_W-1:0] tagIn;
    if (i == 0) begin : gFirst
      assign validIn = inValid;
      assign tagIn   = inTag;
    end else begin : gNext
      assign validIn = validQ[i-1];
      assign tagIn   = tagQ[i-1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        tagQ[i]   <= '0;
      end else begin
        validQ[i] <= validIn;
        if (validIn) tagQ[i] <= tagIn;
      end
    end

    assign strobes.load[i] = validIn;
  end

  assign outValid = validQ[LATENCY-1];
  assign outTag   = tagQ[LATENCY-1];
endmodule

// File: rtl/fmaDatapath.sv
module fmaDatapath
  import fmaPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [WORD_W-1:0] opC,
  output logic [WORD_W-1:0] result
);
  stage1_t s1n, s1q;
  stage2_t s2n, s2q;
  stage3_t s3n, s3q;
  logic [WORD_W-1:0] resN;

  // ---------------- stage 1: unpack, classify, multiply ----------------
  logic [EXP_W-1:0]  aE, bE, cE;
  logic [FRAC_W-1:0] aF, bF, cF;
  logic aZero, bZero, cZero, aNan, bNan, cNan, aInf, bInf, cInf;
  logic pNan, pInf, pZero;
  logic [SIG_W-1:0] sigA, sigB;

  always_comb begin
    aE = opA[FRAC_W +: EXP_W];  aF = opA[FRAC_W-1:0];
    bE = opB[FRAC_W +: EXP_W];  bF = opB[FRAC_W-1:0];
    cE = opC[FRAC_W +: EXP_W];  cF = opC[FRAC_W-1:0];
    aZero = (aE == '0); bZero = (bE == '0); cZero = (cE == '0);
    aNan = (aE == '1) && (aF != '0); aInf = (aE == '1) && (aF == '0);
    bNan = (bE == '1) && (bF != '0); bInf = (bE == '1) && (bF == '0);
    cNan = (cE == '1) && (cF != '0); cInf = (cE == '1) && (cF == '0);
    pNan  = aNan | bNan | (aInf & bZero) | (bInf & aZero);
    pInf  = aInf | bInf;
    pZero = aZero | bZero;
    sigA  = aZero ? '0 : {1'b1, aF};
    sigB  = bZero ? '0 : {1'b1, bF};

    s1n.pSign = opA[WORD_W-1] ^ opB[WORD_W-1];
    s1n.cSign = opC[WORD_W-1];
    s1n.sp.nan      = pNan | cNan | (pInf & cInf & (s1n.pSign != s1n.cSign));
    s1n.sp.inf      = pInf | cInf;
    s1n.sp.infSign  = pInf ? s1n.pSign : s1n.cSign;
    s1n.sp.bothZero = pZero & cZero;
    s1n.sp.zeroSign = s1n.pSign & s1n.cSign;
    s1n.prod = PROD_W'(sigA) * PROD_W'(sigB);
    // exponent of the product's top bit: ea + eb - bias + 1
    s1n.pExp = pZero ? EXP_FLOOR
             : sexp_t'({{(EXPI_W-EXP_W){1'b0}}, aE}) + sexp_t'({{(EXPI_W-EXP_W){1'b0}}, bE})
               - sexp_t'(BIAS - 1);
    s1n.cExp = cZero ? EXP_FLOOR : sexp_t'({{(EXPI_W-EXP_W){1'b0}}, cE});
    s1n.cSig = cZero ? '0 : {1'b1, cF};
  end

  // ---------------- stage 2: align the smaller term ----------------
  logic [ALIGN_W-1:0] pSigW, cSigW, smallRaw, shifted;
  logic [EXPI_W-1:0]  shiftAmt;
  sexp_t              smallExp;
  logic               lost, pIsBig;

  always_comb begin
    pSigW  = {s1q.prod, {EXT_W{1'b0}}};
    cSigW  = {s1q.cSig, {(ALIGN_W-SIG_W){1'b0}}};
    pIsBig = (s1q.pExp >= s1q.cExp);
    s2n.sp       = s1q.sp;
    s2n.effSub   = s1q.pSign ^ s1q.cSign;
    s2n.bigSign  = pIsBig ? s1q.pSign : s1q.cSign;
    s2n.bigExp   = pIsBig ? s1q.pExp  : s1q.cExp;
    s2n.bigSig   = pIsBig ? pSigW     : cSigW;
    smallExp     = pIsBig ? s1q.cExp  : s1q.pExp;
    smallRaw     = pIsBig ? cSigW     : pSigW;
    shiftAmt     = s2n.bigExp - smallExp;
    if (shiftAmt >= EXPI_W'(ALIGN_W)) begin
      shifted = '0;
      lost    = |smallRaw;
    end else begin
      shifted = smallRaw >> shiftAmt;
      lost    = |(smallRaw & ~({ALIGN_W{1'b1}} << shiftAmt));
    end
    // bits shifted out collapse into a sticky LSB
    s2n.smallSig = shifted | {{(ALIGN_W-1){1'b0}}, lost};
  end

  // ---------------- stage 3: add / subtract, normalise ----------------
  logic [SUM_W-1:0] addRes, subRes, mag;
  logic [LZ_W-1:0]  lz;

  always_comb begin
    addRes = {1'b0, s2q.bigSig} + {1'b0, s2q.smallSig};
    subRes = {1'b0, s2q.bigSig} - {1'b0, s2q.smallSig};
    s3n.sp = s2q.sp;
    if (!s2q.effSub) begin
      mag = addRes;   s3n.sign = s2q.bigSign;
    end else if (subRes[SUM_W-1]) begin
      mag = -subRes;  s3n.sign = ~s2q.bigSign;
    end else begin
      mag = subRes;   s3n.sign = s2q.bigSign;
    end
    lz       = leadZeros(mag);
    s3n.norm = mag << lz;
    s3n.exp  = s2q.bigExp + sexp_t'(1) - sexp_t'({{(EXPI_W-LZ_W){1'b0}}, lz});
  end

  // ---------------- stage 4: round to nearest even, pack ----------------
  logic [FRAC_W-1:0] keep;
  logic [FRAC_W:0]   fracR;
  logic              guardBit, stickyBit, roundUp;
  sexp_t             expR;

  always_comb begin
    keep      = s3q.norm[SUM_W-2 : GUARD_POS+1];
    guardBit  = s3q.norm[GUARD_POS];
    stickyBit = |s3q.norm[GUARD_POS-1:0];
    roundUp   = guardBit & (stickyBit | keep[0]);
    fracR     = {1'b0, keep} + {{FRAC_W{1'b0}}, roundUp};
    expR      = s3q.exp + sexp_t'({{(EXPI_W-1){1'b0}}, fracR[FRAC_W]});
    if (s3q.sp.nan)
      resN = QNAN;
    else if (s3q.sp.inf)
      resN = {s3q.sp.infSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (!s3q.norm[SUM_W-1])
      resN = {s3q.sp.bothZero & s3q.sp.zeroSign, {(WORD_W-1){1'b0}}};
    else if (expR < sexp_t'(1))
      resN = {s3q.sign, {(WORD_W-1){1'b0}}};
    else if (expR >= sexp_t'(EXP_MAX))
      resN = {s3q.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      resN = {s3q.sign, expR[EXP_W-1:0], fracR[FRAC_W-1:0]};
  end

  // ---------------- stage registers, loaded on control strobes ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1q    <= '0;
      s2q    <= '0;
      s3q    <= '0;
      result <= '0;
    end else begin
      if (strobes.load[0]) s1q    <= s1n;
      if (strobes.load[1]) s2q    <= s2n;
      if (strobes.load[2]) s3q    <= s3n;
      if (strobes.load[3]) result <= resN;
    end
  end
endmodule

// File: rtl/fmaUnit.sv
module fmaUnit
  import fmaPkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [TAG_W-1:0] inTag,
  input  logic [31:0]      opA,
  input  logic [31:0]      opB,
  input  logic [31:0]      opC,
  output logic             outValid,
  output logic [TAG_W-1:0] outTag,
  output logic [31:0]      outResult
);
  strobe_t strobes;

  fmaCtrl #(.TAG_W(TAG_W)) ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTag(inTag),
    .strobes(strobes), .outValid(outValid), .outTag(outTag)
  );

  fmaDatapath datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .opA(opA), .opB(opB), .opC(opC), .result(outResult)
  );
endmodule

// File: rtl/fmaUnitChecker.sv
module fmaUnitChecker #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [TAG_W-1:0] inTag,
  input logic [31:0]      opA,
  input logic [31:0]      opB,
  input logic [31:0]      opC,
  input logic             outValid,
  input logic [TAG_W-1:0] outTag,
  input logic [31:0]      outResult
);
  localparam logic [31:0] CANON_NAN = 32'h7FC0_0000;

  // edges seen since reset, saturating once the pipe is full
  logic [2:0] age;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) age <= '0;
    else if (age != 3'd4) age <= age + 3'd1;
  end

  logic nanIn, infZeroIn;
  always_comb begin
    nanIn = ((opA[30:23] == 8'hFF) && (opA[22:0] != '0)) ||
            ((opB[30:23] == 8'hFF) && (opB[22:0] != '0)) ||
            ((opC[30:23] == 8'hFF) && (opC[22:0] != '0));
    infZeroIn = ((opA[30:0] == 31'h7F80_0000) && (opB[30:23] == 8'h00)) ||
                ((opB[30:0] == 31'h7F80_0000) && (opA[30:23] == 8'h00));
  end

  // R2: four-cycle latency on the valid bit
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (age == 3'd4) |-> (outValid == $past(inValid, 4)));

  // R3: tag follows its operation
  assert_tag_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    (age == 3'd4 && outValid) |-> (outTag == $past(inTag, 4)));

  // R8: NaN operand gives the canonical quiet NaN
  assert_nan_input_R8: assert property (@(posedge clk) disable iff (!rstN)
    (age == 3'd4 && outValid && $past(inValid && nanIn, 4)) |-> (outResult == CANON_NAN));

  // R8: no other NaN pattern is ever produced
  assert_canonical_nan_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outResult[30:23] == 8'hFF && outResult[22:0] != '0) |-> (outResult == CANON_NAN));

  // R9: infinity times zero is invalid
  assert_inf_times_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (age == 3'd4 && outValid && $past(inValid && infZeroIn && !nanIn, 4)) |-> (outResult == CANON_NAN));

  // R7: results are never subnormal
  assert_no_subnormal_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outResult[30:23] != 8'h00 || outResult[22:0] == '0));
endmodule

bind fmaUnit fmaUnitChecker #(.TAG_W(TAG_W)) checker0 (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inTag(inTag),
  .opA(opA), .opB(opB), .opC(opC),
  .outValid(outValid), .outTag(outTag), .outResult(outResult)
);

// File: tb/tb_fmaUnit.sv
`timescale 1ns/1ps
module tb_fmaUnit;
  localparam int TAG_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [TAG_W-1:0] inTag = '0;
  logic [31:0]      opA = '0, opB = '0, opC = '0;
  logic             outValid;
  logic [TAG_W-1:0] outTag;
  logic [31:0]      outResult;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  fmaUnit #(.TAG_W(TAG_W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTag(inTag),
    .opA(opA), .opB(opB), .opC(opC),
    .outValid(outValid), .outTag(outTag), .outResult(outResult)
  );

  typedef struct {
    bit               v;
    logic [TAG_W-1:0] t;
    logic [31:0]      r;
    string            req;
  } expect_t;

  expect_t pending[$];

  // ---------------- reference model from real arithmetic ----------------
  function automatic real toReal(input logic [31:0] x);
    real m;
    if (x[30:23] == 8'h00) return 0.0;
    m = real'({1'b1, x[22:0]}) * (2.0 ** (real'(int'(x[30:23])) - 150.0));
    return x[31] ? -m : m;
  endfunction

  function automatic logic [31:0] roundSingle(input real x);
    logic [63:0] bits;
    logic [52:0] m53;
    logic [24:0] mk;
    logic        up;
    int          e;
    if (x == 0.0) return 32'h0000_0000;
    bits = $realtobits(x);
    m53  = {1'b1, bits[51:0]};
    e    = int'(bits[62:52]) - 1023 + 127;
    up   = m53[28] && ((|m53[27:0]) || m53[29]);
    mk   = {1'b0, m53[52:29]} + {24'd0, up};
    if (mk[24]) begin
      mk = 25'h080_0000;
      e  = e + 1;
    end
    if (e < 1)   return {bits[63], 31'd0};
    if (e >= 255) return {bits[63], 8'hFF, 23'd0};
    return {bits[63], e[7:0], mk[22:0]};
  endfunction

  function automatic logic [31:0] refFma(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] c);
    bit aN = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bit bN = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    bit cN = (c[30:23] == 8'hFF) && (c[22:0] != 0);
    bit aI = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    bit bI = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    bit cI = (c[30:23] == 8'hFF) && (c[22:0] == 0);
    bit aZ = (a[30:23] == 8'h00);
    bit bZ = (b[30:23] == 8'h00);
    bit cZ = (c[30:23] == 8'h00);
    bit ps = a[31] ^ b[31];
    bit pI = aI || bI;
    if (aN || bN || cN || (aI && bZ) || (bI && aZ) || (pI && cI && (ps != c[31])))
      return 32'h7FC0_0000;                                   // R8, R9
    if (pI) return {ps, 8'hFF, 23'd0};                        // R10
    if (cI) return {c[31], 8'hFF, 23'd0};                     // R10
    if ((aZ || bZ) && cZ) return {ps & c[31], 31'd0};         // R11
    return roundSingle(toReal(a) * toReal(b) + toReal(c));    // R1, R5, R6, R7
  endfunction

  // ---------------- checking and driving ----------------
  task automatic fail(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
    fails++;
    $display("FAIL %s: %s actual %h expected %h", req, what, act, expv);
  endtask

  task automatic step(input bit v, input logic [TAG_W-1:0] t, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] c, input string req);
    expect_t e, got;
    @(negedge clk);
    if (pending.size() > 0) begin
      got = pending.pop_front();
      checks++;
      if (outValid !== got.v)
        fail(got.v ? "R2" : "R12", "outValid", {31'd0, outValid}, {31'd0, got.v});
      if (got.v) begin
        checks++;
        if (outTag !== got.t) fail("R3", "outTag", {28'd0, outTag}, {28'd0, got.t});
        checks++;
        if (outResult !== got.r) fail(got.req, "outResult", outResult, got.r);
      end
    end
    inValid = v; inTag = t; opA = a; opB = b; opC = c;
    e.v = v; e.t = t; e.r = refFma(a, b, c); e.req = req;
    pending.push_back(e);
  endtask

  task automatic op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                    input string req);
    step(1'b1, TAG_W'($urandom), a, b, c, req);
  endtask

  // operands whose exact result fits a double: short A/B significands, nearby C exponent
  task automatic randomOp(input bit v, input string req);
    logic [7:0] ea, eb, ec;
    logic [31:0] a, b, c;
    ea = 8'(120 + $urandom % 15);
    eb = 8'(120 + $urandom % 15);
    ec = 8'(int'(ea) + int'(eb) - 127 + int'($urandom % 17) - 8);
    a  = {1'($urandom), ea, 12'($urandom), 11'd0};
    b  = {1'($urandom), eb, 12'($urandom), 11'd0};
    c  = {1'($urandom), ec, 23'($urandom)};
    step(v, TAG_W'($urandom), a, b, c, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0) fail("R2", "outValid in reset", {31'd0, outValid}, 32'd0);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      expect_t idle;
      idle.v = 1'b0; idle.t = '0; idle.r = '0; idle.req = "R2";
      pending.push_back(idle);
    end

    // R1: plain cases
    op(32'h3FC0_0000, 32'h4000_0000, 32'h3F80_0000, "R1");   // 1.5*2+1 = 4
    op(32'h4040_0000, 32'hBF80_0000, 32'h4000_0000, "R1");   // 3*-1+2 = -1
    op(32'h3F80_0000, 32'h3F80_0000, 32'h0000_0000, "R1");   // 1*1+0
    // R5: half-ulp ties, one rounding down to even, one rounding up to even
    op(32'h3F80_0800, 32'h3F80_0800, 32'h0000_0000, "R5");
    op(32'h3F80_0800, 32'h3F80_0800, 32'h3400_0000, "R5");
    op(32'hBF80_0800, 32'h3F80_0800, 32'hB400_0000, "R5");
    // R6: subnormal operands act as zero
    op(32'h0000_0001, 32'h4000_0000, 32'h3F80_0000, "R6");
    op(32'h3F80_0000, 32'h3F80_0000, 32'h807F_FFFF, "R6");
    op(32'h0040_0000, 32'hBF80_0000, 32'h8000_0001, "R6");
    // R7: overflow and underflow
    op(32'h7180_0000, 32'h7180_0000, 32'h3F80_0000, "R7");
    op(32'hF180_0000, 32'h7180_0000, 32'h3F80_0000, "R7");
    op(32'h1C80_0000, 32'h1C80_0000, 32'h0000_0000, "R7");
    op(32'h9C80_0000, 32'h1C80_0000, 32'h0000_0000, "R7");
    // R8: NaN operands
    op(32'h7F80_0001, 32'h3F80_0000, 32'h3F80_0000, "R8");
    op(32'h3F80_0000, 32'hFFC1_2345, 32'h3F80_0000, "R8");
    op(32'h3F80_0000, 32'h3F80_0000, 32'h7FFF_FFFF, "R8");
    // R9: invalid infinity cases
    op(32'h7F80_0000, 32'h0000_0000, 32'h3F80_0000, "R9");
    op(32'h8000_0000, 32'hFF80_0000, 32'h3F80_0000, "R9");
    op(32'h7F80_0000, 32'h3F80_0000, 32'hFF80_0000, "R9");
    // R10: infinity propagation
    op(32'h7F80_0000, 32'hC000_0000, 32'h3F80_0000, "R10");
    op(32'h3F80_0000, 32'h3F80_0000, 32'hFF80_0000, "R10");
    op(32'h7F80_0000, 32'h3F80_0000, 32'h7F80_0000, "R10");
    // R11: zero signs
    op(32'h3F80_0000, 32'h3F80_0000, 32'hBF80_0000, "R11");
    op(32'hBF80_0000, 32'h3F80_0000, 32'h3F80_0000, "R11");
    op(32'h0000_0000, 32'hBF80_0000, 32'h8000_0000, "R11");
    op(32'h0000_0000, 32'h3F80_0000, 32'h8000_0000, "R11");
    // R12: bubbles carrying garbage operands
    step(1'b0, 4'hA, 32'h7F80_0001, 32'h7F80_0000, 32'hFFFF_FFFF, "R12");
    step(1'b0, 4'h5, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, "R12");
    op(32'h4000_0000, 32'h4000_0000, 32'h4000_0000, "R12");

    // R1: random traffic with occasional gaps
    for (int i = 0; i < 1500; i++) randomOp(($urandom % 5) != 0, "R1");
    // R4: back-to-back stream
    for (int i = 0; i < 300; i++) randomOp(1'b1, "R4");
    for (int i = 0; i < 6; i++) step(1'b0, '0, '0, '0, '0, "R12");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule